// File: doc/BRIEF.md
# Overlapped Asynchronous Event Catcher

This block catches brief, active-low glitches on one or more event lines so that a periodic reader never misses them, however short they are and whenever they arrive. Each line feeds two capture flops. A low level sets a flop asynchronously. The flop's data input is held at zero, so each of its active clock edges clears it again. One flop clears on the rising edge of the sample clock and the other on the falling edge. An event that lands on one flop's clearing edge is therefore still held by the other flop.

Just before a flop clears, its state is copied into a read register. The per-lane event flag is the OR of the two read registers. A short event thus shows up on the flag for one and a half sample periods. This stretch is expected. No delay or constant in the block depends on the sample rate.

Top module: `overlap_event_catcher`

## Requirements
- R1: While reset is low, and after reset release while every event line stays high, rise_seen_o, fall_seen_o and event_flag_o are all zero.
- R2: A low pulse on a lane that lies wholly between two clock edges raises that lane's rise_seen_o bit for exactly the one period that follows the next rising edge.
- R3: The same pulse raises that lane's fall_seen_o bit for exactly the one period that follows the next falling edge.
- R4: A low pulse that spans a clock edge is not lost. It holds the phase that clears on that edge for two periods, and the other phase reports it for one period.
- R5: event_flag_o is the bitwise OR of rise_seen_o and fall_seen_o. A short pulse sets it for one and a half periods.
- R6: While a lane is held low, every sample reports that lane as captured on both phases.
- R7: Lanes are independent. A pulse on some lanes leaves the output bits of the other lanes at zero.
- R8: Pulses far shorter than a clock period, at any offset within the period, are captured. A lane held high reports nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock; rising and falling edges are the two phases |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| event_ni | input | LANES | Active-low asynchronous event lines, idle high |
| rise_seen_o | output | LANES | Read register of the rising-edge phase |
| fall_seen_o | output | LANES | Read register of the falling-edge phase |
| event_flag_o | output | LANES | Combined per-sample event flag |

## Verification
The assertions see event lines only at clock edges. They assume that a line found low at an edge either went low before that edge or is held through it. They also assume that no event line is low when reset is released. The stimulus meets these assumptions. Each short pulse is placed strictly between edges, or it spans a single edge by a fixed margin on both sides. Reset is always released with all lines high, and several idle periods separate successive patterns so that the expected windows never overlap.

// File: rtl/evc_pkg.sv
package evc_pkg;

  typedef enum logic {
    PHASE_RISE = 1'b0,
    PHASE_FALL = 1'b1
  } phase_e;

  localparam logic CLEAR_LEVEL = 1'b0;
  localparam logic SET_LEVEL   = 1'b1;

endpackage

// File: rtl/evc_reset_sync.sv
module evc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/evc_capture_cell.sv
module evc_capture_cell
  import evc_pkg::*;
#(
  parameter phase_e PHASE = PHASE_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_ni,
  output logic seen_o
);

  logic hold_q;
  logic hold_d;
  logic read_q;
  logic read_d;

  // Data input of the capture flop is tied to the idle level.
  always_comb begin
    hold_d = CLEAR_LEVEL;
    read_d = hold_q;
  end

  if (PHASE == PHASE_RISE) begin : g_rise
    always_ff @(posedge clk_i or negedge rst_ni or negedge set_ni) begin
      if (!rst_ni) begin
        hold_q <= CLEAR_LEVEL;
      end else if (!set_ni) begin
        hold_q <= SET_LEVEL;
      end else begin
        hold_q <= hold_d;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        read_q <= CLEAR_LEVEL;
      end else begin
        read_q <= read_d;
      end
    end
  end else begin : g_fall
    always_ff @(negedge clk_i or negedge rst_ni or negedge set_ni) begin
      if (!rst_ni) begin
        hold_q <= CLEAR_LEVEL;
      end else if (!set_ni) begin
        hold_q <= SET_LEVEL;
      end else begin
        hold_q <= hold_d;
      end
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        read_q <= CLEAR_LEVEL;
      end else begin
        read_q <= read_d;
      end
    end
  end

  assign seen_o = read_q;

endmodule

// File: rtl/evc_phase_bank.sv
module evc_phase_bank
  import evc_pkg::*;
#(
  parameter int     LANES = 4,
  parameter phase_e PHASE = PHASE_RISE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] event_ni,
  output logic [LANES-1:0] seen_o
);

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    evc_capture_cell #(
      .PHASE (PHASE)
    ) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_ni (event_ni[lane]),
      .seen_o (seen_o[lane])
    );
  end

endmodule

// File: rtl/evc_merge.sv
module evc_merge #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] rise_seen_i,
  input  logic [LANES-1:0] fall_seen_i,
  output logic [LANES-1:0] flag_o
);

  always_comb begin
    for (int lane = 0; lane < LANES; lane++) begin
      flag_o[lane] = rise_seen_i[lane] | fall_seen_i[lane];
    end
  end

endmodule

// File: rtl/overlap_event_catcher.sv
module overlap_event_catcher
  import evc_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] event_ni,
  output logic [LANES-1:0] rise_seen_o,
  output logic [LANES-1:0] fall_seen_o,
  output logic [LANES-1:0] event_flag_o
);

  logic             rst_q_n;
  logic [LANES-1:0] rise_seen;
  logic [LANES-1:0] fall_seen;

  evc_reset_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_q_n)
  );

  evc_phase_bank #(
    .LANES (LANES),
    .PHASE (PHASE_RISE)
  ) u_rise_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_q_n),
    .event_ni (event_ni),
    .seen_o   (rise_seen)
  );

  evc_phase_bank #(
    .LANES (LANES),
    .PHASE (PHASE_FALL)
  ) u_fall_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_q_n),
    .event_ni (event_ni),
    .seen_o   (fall_seen)
  );

  evc_merge #(
    .LANES (LANES)
  ) u_merge (
    .rise_seen_i (rise_seen),
    .fall_seen_i (fall_seen),
    .flag_o      (event_flag_o)
  );

  assign rise_seen_o = rise_seen;
  assign fall_seen_o = fall_seen;

endmodule

// File: rtl/overlap_event_catcher_chk.sv
module overlap_event_catcher_chk #(
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_q_n,
  input logic [LANES-1:0] event_ni,
  input logic [LANES-1:0] rise_seen_o,
  input logic [LANES-1:0] fall_seen_o,
  input logic [LANES-1:0] event_flag_o
);

  always @(posedge clk_i) begin
    if (!rst_q_n) begin
      // R1
      idle_in_reset_chk: assert (rise_seen_o == '0 && fall_seen_o == '0 && event_flag_o == '0)
        else $error("outputs not idle during reset");
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R2
    rise_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
      !event_ni[i] |=> rise_seen_o[i]);

    // R3
    fall_capture_chk: assert property (@(negedge clk_i) disable iff (!rst_q_n)
      !event_ni[i] |=> fall_seen_o[i]);

    // R5
    flag_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
      !event_ni[i] |=> event_flag_o[i]);

    // R6
    held_low_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
      (!event_ni[i] && $past(!event_ni[i])) |-> (rise_seen_o[i] && fall_seen_o[i]));
  end

endmodule

bind overlap_event_catcher overlap_event_catcher_chk #(
  .LANES (LANES)
) u_chk (
  .clk_i        (clk_i),
  .rst_q_n      (rst_q_n),
  .event_ni     (event_ni),
  .rise_seen_o  (rise_seen_o),
  .fall_seen_o  (fall_seen_o),
  .event_flag_o (event_flag_o)
);

// File: tb/overlap_event_catcher_bench.sv
`timescale 1ns/1ps
module overlap_event_catcher_bench;

  localparam int  LANES = 4;
  localparam real HALF  = 4.0;

  typedef struct {
    realtime          t;
    logic [LANES-1:0] a;
    logic [LANES-1:0] b;
    string            req;
  } exp_t;

  logic             clk;
  logic             rst_n;
  logic [LANES-1:0] evt_n;
  logic [LANES-1:0] rise_seen;
  logic [LANES-1:0] fall_seen;
  logic [LANES-1:0] flag;

  exp_t exp_q[$];
  int   checks;
  int   fails;
  bit   done;

  overlap_event_catcher #(.LANES(LANES)) u_overlap_event_catcher (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .event_ni     (evt_n),
    .rise_seen_o  (rise_seen),
    .fall_seen_o  (fall_seen),
    .event_flag_o (flag)
  );

  initial begin
    clk = 1'b0;
    forever #(HALF) clk = ~clk;
  end

  task automatic check(input string req, input string what,
                       input logic [LANES-1:0] got, input logic [LANES-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: got %b expected %b", req, what, $realtime, got, exp);
    end
  endtask

  task automatic push(input realtime t, input logic [LANES-1:0] a,
                      input logic [LANES-1:0] b, input string req);
    exp_t e;
    e.t = t; e.a = a; e.b = b; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: samples 2 ns after every clock edge and compares queued items.
  initial begin
    forever begin
      @(clk);
      #2;
      while (exp_q.size() > 0 && exp_q[0].t <= $realtime + 0.01) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.t < $realtime - 0.01) begin
          checks++; fails++;
          $display("FAIL %s missed sample at %0t: got none expected sample", e.req, e.t);
        end else begin
          check(e.req, "rise_seen", rise_seen, e.a);
          check(e.req, "fall_seen", fall_seen, e.b);
          check(e.req, "event_flag", flag, e.a | e.b);
        end
      end
    end
  end

  task automatic idle_cycles(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
  endtask

  // Short pulse at offset o (ns) after a rising edge, on the lanes in mask.
  task automatic short_pulse(input logic [LANES-1:0] mask, input real o, input string req);
    realtime p0;
    logic [LANES-1:0] z;
    z = '0;
    @(posedge clk);
    p0 = $realtime;
    push(p0 + 6,  z,    (o < HALF) ? mask : z, req);
    push(p0 + 10, mask, (o < HALF) ? mask : z, req);
    push(p0 + 14, mask, (o < HALF) ? z : mask, req);
    push(p0 + 18, z,    (o < HALF) ? z : mask, req);
    push(p0 + 22, z,    z, req);
    #(o);
    evt_n = evt_n & ~mask;
    #0.3;
    evt_n = evt_n | mask;
    idle_cycles(5);
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0;
    evt_n = '1;
    #10;
    check("R1", "rise_seen in reset", rise_seen, '0);
    check("R1", "fall_seen in reset", fall_seen, '0);
    check("R1", "flag in reset", flag, '0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(4);

    // R8: idle lines report nothing
    @(posedge clk);
    for (int k = 0; k < 4; k++) push($realtime + 2 + k*HALF, '0, '0, "R8");
    idle_cycles(3);

    // R2 R3 R5 R8: short pulses at several offsets
    short_pulse(4'b0001, 1.0, "R2");
    short_pulse(4'b0001, 2.5, "R3");
    short_pulse(4'b0010, 5.0, "R2");
    short_pulse(4'b0010, 6.5, "R3");
    short_pulse(4'b1000, 0.5, "R5");
    short_pulse(4'b1000, 7.2, "R8");

    // R7: two lanes together, others must stay zero
    short_pulse(4'b0101, 2.0, "R7");
    short_pulse(4'b1010, 5.5, "R7");

    // R4: pulse spanning a rising edge (the rising phase clear edge)
    begin
      realtime p0;
      @(posedge clk);
      #7;
      evt_n[2] = 1'b0;
      p0 = $realtime + 1;
      push(p0 + 2,  4'b0100, 4'b0000, "R4");
      push(p0 + 6,  4'b0100, 4'b0100, "R4");
      push(p0 + 10, 4'b0100, 4'b0100, "R4");
      push(p0 + 14, 4'b0100, 4'b0000, "R4");
      push(p0 + 18, 4'b0000, 4'b0000, "R4");
      #2;
      evt_n[2] = 1'b1;
      idle_cycles(5);
    end

    // R4: pulse spanning a falling edge
    begin
      realtime p0;
      @(posedge clk);
      p0 = $realtime;
      push(p0 + 6,  4'b0000, 4'b0001, "R4");
      push(p0 + 10, 4'b0001, 4'b0001, "R4");
      push(p0 + 14, 4'b0001, 4'b0001, "R4");
      push(p0 + 18, 4'b0000, 4'b0001, "R4");
      push(p0 + 22, 4'b0000, 4'b0000, "R4");
      #3;
      evt_n[0] = 1'b0;
      #2;
      evt_n[0] = 1'b1;
      idle_cycles(5);
    end

    // R6: lane held low for three periods
    begin
      realtime p0;
      @(posedge clk);
      p0 = $realtime;
      for (int k = 0; k < 5; k++) push(p0 + 10 + k*HALF, 4'b0010, 4'b0010, "R6");
      #1;
      evt_n[1] = 1'b0;
      #24;
      evt_n[1] = 1'b1;
      idle_cycles(6);
    end

    // R1: reset asserted while a lane is low clears everything at once
    @(posedge clk);
    #1;
    evt_n[3] = 1'b0;
    #9;
    rst_n = 1'b0;
    #1;
    check("R1", "rise_seen after reset", rise_seen, '0);
    check("R1", "fall_seen after reset", fall_seen, '0);
    check("R1", "flag after reset", flag, '0);
    evt_n[3] = 1'b1;
    idle_cycles(2);
    @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(4);
    @(negedge clk);
    #1;
    check("R1", "rise_seen after release", rise_seen, '0);
    check("R1", "fall_seen after release", fall_seen, '0);
    check("R1", "flag after release", flag, '0);

    idle_cycles(4);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: got %0d unchecked items expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 2 * HALF);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule